// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds a small set of instructions that wait in front of one functional unit. Issue logic hands it an opcode and two source operands. Each operand is either a value or the tag of the station that will produce it. The pool allocates a free slot and reports that slot's own tag back, so the issue side can record it as the rename for the destination. While an operand is still pending, the slot listens to a single result-broadcast bus and takes the data when the bus tag matches.

A slot whose operands are both present competes for the functional unit. Only one slot is dispatched per cycle, and the oldest competitor wins. A busy input from the unit holds every ready slot in place while the unit is occupied. The unit then reports completion by tag, and the slot waits in a completed state until its own result appears on the broadcast bus, which frees it. If every slot is in use, the pool raises a stall to the issue logic and ignores any issue request.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free: `iss_stall` is 0, `disp_valid` is 0, and `iss_tag` shows the tag of slot 0.
- R2: A slot's own tag is the unit prefix `UNIT_ID` in the upper bits and the slot index in the lower `IDX_W` bits, so by default slot k has tag 4+k. An accepted issue goes into the lowest-indexed free slot, whose tag `iss_tag` shows during the issue cycle. An issue whose operands are both present (tag 0) appears on the dispatch port in the next cycle with its opcode, operand values and tag.
- R3: An operand tag of 0 means the value is present. A nonzero tag means the value is pending. A broadcast with `bus_valid` high writes `bus_data` into every pending operand, in every slot, whose tag equals `bus_tag`, all in the same cycle.
- R4: If an issued operand's tag equals the tag on the broadcast bus in the issue cycle, the bus data is taken as that operand's value, and the slot does not wait for it.
- R5: While no slot is free, `iss_stall` is 1, and an issue request has no effect on any slot.
- R6: At most one slot is dispatched per cycle. Among ready slots, the one issued earliest goes first, whatever its index.
- R7: While `fu_busy` is 1, `disp_valid` is 0, and ready slots stay ready until it drops.
- R8: A dispatched slot is executing. `fu_done` with that slot's tag moves it to completed. A broadcast carrying that slot's tag then frees it for a later issue.
- R9: A slot with one operand still pending is never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of the issued instruction |
| iss_a_tag | input | TAG_W | Producer tag of operand A, 0 if the value is present |
| iss_a_val | input | DATA_W | Value of operand A |
| iss_b_tag | input | TAG_W | Producer tag of operand B, 0 if the value is present |
| iss_b_val | input | DATA_W | Value of operand B |
| iss_stall | output | 1 | No free slot; the issue request is refused |
| iss_tag | output | TAG_W | Tag of the slot an issue in this cycle will take |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_data | input | DATA_W | Broadcast result value |
| fu_busy | input | 1 | Functional unit cannot accept work |
| fu_done | input | 1 | Functional unit finished an operation |
| fu_done_tag | input | TAG_W | Tag of the finished operation |
| disp_valid | output | 1 | A slot is dispatched this cycle |
| disp_op | output | OP_W | Opcode of the dispatched slot |
| disp_a | output | DATA_W | Operand A value of the dispatched slot |
| disp_b | output | DATA_W | Operand B value of the dispatched slot |
| disp_tag | output | TAG_W | Tag of the dispatched slot |

## Verification
Two functions can coincide in one cycle: an issue and a result broadcast whose tag matches an incoming operand. The bench drives both in the same cycle. It then expects the slot to be on the dispatch port one cycle later, carrying the broadcast data, with no further broadcast. A second coincidence is a broadcast that wakes two slots while `fu_busy` holds dispatch. After the busy input drops, the bench expects the older slot first even though it has the higher index, and the younger one in the following cycle.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;

    typedef enum logic [2:0] {
        ST_FREE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_READY = 3'd2,
        ST_EXEC  = 3'd3,
        ST_DONE  = 3'd4
    } rs_state_e;

endpackage

// File: rtl/rs_operand.sv
`timescale 1ns/1ps
// Next-value logic for one operand slot: a pending tag is replaced by
// the broadcast data when the bus carries the same tag.
module rs_operand #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic [DATA_W-1:0] cur_val,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic [TAG_W-1:0]  nxt_tag,
    output logic [DATA_W-1:0] nxt_val
);
    logic hit;

    always_comb begin
        hit     = bus_valid && (cur_tag != '0) && (bus_tag == cur_tag);
        nxt_tag = hit ? '0 : cur_tag;
        nxt_val = hit ? bus_data : cur_val;
    end
endmodule

// File: rtl/rs_lowest_free.sv
`timescale 1ns/1ps
// Priority encoder: lowest set bit of a vector.
module rs_lowest_free #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_dispatch_sel.sv
`timescale 1ns/1ps
// Picks one requesting slot per cycle. OLDEST=1 keeps an age matrix
// updated on allocation; OLDEST=0 uses a fixed lowest-index priority.
module rs_dispatch_sel #(
    parameter int N      = 4,
    parameter bit OLDEST = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_oh,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    generate
        if (OLDEST) begin : g_age
            // older_q[i][j] set: slot i was allocated before slot j
            logic [N-1:0][N-1:0] older_d, older_q;

            always_comb begin
                older_d = older_q;
                for (int k = 0; k < N; k++) begin
                    if (alloc_oh[k]) begin
                        for (int j = 0; j < N; j++) begin
                            if (j != k) begin
                                older_d[j][k] = 1'b1;
                                older_d[k][j] = 1'b0;
                            end
                        end
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) older_q <= '0;
                else        older_q <= older_d;
            end

            always_comb begin
                for (int i = 0; i < N; i++) begin
                    grant[i] = req[i];
                    for (int j = 0; j < N; j++) begin
                        if (j != i && req[j] && older_q[j][i]) grant[i] = 1'b0;
                    end
                end
            end
        end else begin : g_fixed
            logic unused_sel;
            assign unused_sel = ^{clk, rst_n, alloc_oh};

            always_comb begin
                grant = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) grant = N'(1) << i;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rs_pool.sv
`timescale 1ns/1ps
module rs_pool #(
    parameter int N       = 4,
    parameter int DATA_W  = 32,
    parameter int OP_W    = 4,
    parameter int TYPE_W  = 2,
    parameter int UNIT_ID = 1,
    parameter bit OLDEST  = 1'b1,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int TAG_W  = TYPE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_val,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_val,
    output logic              iss_stall,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              fu_busy,
    input  logic              fu_done,
    input  logic [TAG_W-1:0]  fu_done_tag,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b,
    output logic [TAG_W-1:0]  disp_tag
);
    import rs_pkg::*;

    typedef struct packed {
        rs_state_e         st;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  a_tag;
        logic [DATA_W-1:0] a_val;
        logic [TAG_W-1:0]  b_tag;
        logic [DATA_W-1:0] b_val;
    } entry_t;

    function automatic logic [TAG_W-1:0] own_tag(input int i);
        own_tag = {TYPE_W'(UNIT_ID), IDX_W'(i)};
    endfunction

    entry_t ent_d [N];
    entry_t ent_q [N];

    logic [N-1:0]      free_vec, ready_vec, exec_vec, req_vec, grant_vec, alloc_oh;
    logic              free_found, iss_accept;
    logic [IDX_W-1:0]  free_idx;

    logic [TAG_W-1:0]  wa_tag [N];
    logic [DATA_W-1:0] wa_val [N];
    logic [TAG_W-1:0]  wb_tag [N];
    logic [DATA_W-1:0] wb_val [N];
    logic [TAG_W-1:0]  ia_tag, ib_tag;
    logic [DATA_W-1:0] ia_val, ib_val;

    // Per-slot wakeup logic
    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opa (
                .cur_tag(ent_q[g].a_tag), .cur_val(ent_q[g].a_val),
                .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
                .nxt_tag(wa_tag[g]), .nxt_val(wa_val[g])
            );
            rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opb (
                .cur_tag(ent_q[g].b_tag), .cur_val(ent_q[g].b_val),
                .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
                .nxt_tag(wb_tag[g]), .nxt_val(wb_val[g])
            );
            assign free_vec[g]  = (ent_q[g].st == ST_FREE);
            assign ready_vec[g] = (ent_q[g].st == ST_READY);
            assign exec_vec[g]  = (ent_q[g].st == ST_EXEC);
            assign req_vec[g]   = ready_vec[g] && !fu_busy;
        end
    endgenerate

    // Same-cycle capture for operands arriving on the issue port
    rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_iss_a (
        .cur_tag(iss_a_tag), .cur_val(iss_a_val),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .nxt_tag(ia_tag), .nxt_val(ia_val)
    );
    rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_iss_b (
        .cur_tag(iss_b_tag), .cur_val(iss_b_val),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .nxt_tag(ib_tag), .nxt_val(ib_val)
    );

    rs_lowest_free #(.N(N), .IDX_W(IDX_W)) u_free (
        .vec(free_vec), .found(free_found), .idx(free_idx)
    );

    rs_dispatch_sel #(.N(N), .OLDEST(OLDEST)) u_sel (
        .clk(clk), .rst_n(rst_n), .alloc_oh(alloc_oh),
        .req(req_vec), .grant(grant_vec)
    );

    always_comb begin
        iss_stall  = !free_found;
        iss_accept = iss_valid && free_found;
        iss_tag    = own_tag(int'(free_idx));
        alloc_oh   = iss_accept ? (N'(1) << free_idx) : '0;
    end

    // Next state of every slot
    always_comb begin
        for (int i = 0; i < N; i++) begin
            ent_d[i] = ent_q[i];
            case (ent_q[i].st)
                ST_WAIT: begin
                    ent_d[i].a_tag = wa_tag[i];
                    ent_d[i].a_val = wa_val[i];
                    ent_d[i].b_tag = wb_tag[i];
                    ent_d[i].b_val = wb_val[i];
                    if (wa_tag[i] == '0 && wb_tag[i] == '0) ent_d[i].st = ST_READY;
                end
                ST_READY: if (grant_vec[i]) ent_d[i].st = ST_EXEC;
                ST_EXEC:  if (fu_done && fu_done_tag == own_tag(i)) ent_d[i].st = ST_DONE;
                ST_DONE:  if (bus_valid && bus_tag == own_tag(i)) ent_d[i].st = ST_FREE;
                default:  ;
            endcase
            if (alloc_oh[i]) begin
                ent_d[i].st    = (ia_tag == '0 && ib_tag == '0) ? ST_READY : ST_WAIT;
                ent_d[i].op    = iss_op;
                ent_d[i].a_tag = ia_tag;
                ent_d[i].a_val = ia_val;
                ent_d[i].b_tag = ib_tag;
                ent_d[i].b_val = ib_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '{st: ST_FREE, default: '0};
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    // Dispatch port: OR of the granted slot's fields
    always_comb begin
        disp_valid = |grant_vec;
        disp_op    = '0;
        disp_a     = '0;
        disp_b     = '0;
        disp_tag   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant_vec[i]) begin
                disp_op  = disp_op  | ent_q[i].op;
                disp_a   = disp_a   | ent_q[i].a_val;
                disp_b   = disp_b   | ent_q[i].b_val;
                disp_tag = disp_tag | own_tag(i);
            end
        end
    end
endmodule

// File: rtl/rs_pool_chk.sv
`timescale 1ns/1ps
module rs_pool_chk #(
    parameter int N     = 4,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic             iss_stall,
    input logic             bus_valid,
    input logic [TAG_W-1:0] bus_tag,
    input logic             fu_busy,
    input logic             disp_valid,
    input logic [N-1:0]     grant_vec,
    input logic [N-1:0]     free_vec,
    input logic [N-1:0]     exec_vec
);
    assert_one_dispatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fu_busy |-> !disp_valid);

    // Nothing frees a slot except a broadcast
    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_stall && !bus_valid) |=> iss_stall);

    assert_dispatch_executes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> (exec_vec != '0));

    assert_issue_takes_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall && !bus_valid) |=>
            ($countones(free_vec) + 1 == $past($countones(free_vec))));

    assert_bus_tag_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_tag != '0));
endmodule

bind rs_pool rs_pool_chk #(.N(N), .TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_stall(iss_stall),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .fu_busy(fu_busy),
    .disp_valid(disp_valid), .grant_vec(grant_vec), .free_vec(free_vec),
    .exec_vec(exec_vec)
);

// File: tb/tb_rs_pool.sv
`timescale 1ns/1ps
module tb_rs_pool;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [3:0]    iss_op = '0;
    logic [3:0]    iss_a_tag = '0, iss_b_tag = '0;
    logic [DW-1:0] iss_a_val = '0, iss_b_val = '0;
    logic          iss_stall;
    logic [3:0]    iss_tag;
    logic          bus_valid = 1'b0;
    logic [3:0]    bus_tag = '0;
    logic [DW-1:0] bus_data = '0;
    logic          fu_busy = 1'b0, fu_done = 1'b0;
    logic [3:0]    fu_done_tag = '0;
    logic          disp_valid;
    logic [3:0]    disp_op;
    logic [DW-1:0] disp_a, disp_b;
    logic [3:0]    disp_tag;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    rs_pool dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_tag(iss_a_tag), .iss_a_val(iss_a_val),
        .iss_b_tag(iss_b_tag), .iss_b_val(iss_b_val),
        .iss_stall(iss_stall), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .fu_busy(fu_busy), .fu_done(fu_done), .fu_done_tag(fu_done_tag),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a),
        .disp_b(disp_b), .disp_tag(disp_tag)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    // All drivers run one time unit after a rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        bus_valid = 1'b0;
        fu_done   = 1'b0;
    endtask

    task automatic drive_issue(input logic [3:0] op, input logic [3:0] at, input int av,
                               input logic [3:0] bt, input int bv);
        iss_valid = 1'b1; iss_op = op;
        iss_a_tag = at; iss_a_val = DW'(av);
        iss_b_tag = bt; iss_b_val = DW'(bv);
    endtask

    task automatic bcast(input logic [3:0] t, input int d);
        bus_valid = 1'b1; bus_tag = t; bus_data = DW'(d);
        tick();
    endtask

    task automatic finish_slot(input logic [3:0] t);
        fu_done = 1'b1; fu_done_tag = t;
        tick();
        bcast(t, 0);
    endtask

    task automatic t_reset();
        chk_eq("R1 stall", iss_stall, 0);
        chk_eq("R1 disp_valid", disp_valid, 0);
        chk_eq("R1 iss_tag", iss_tag, 4);
    endtask

    task automatic t_ready_issue();
        drive_issue(4'd3, 4'd0, 11, 4'd0, 22);
        #1 chk_eq("R2 iss_tag slot0", iss_tag, 4);
        tick();
        chk_eq("R2 disp_valid", disp_valid, 1);
        chk_eq("R2 disp_op", disp_op, 3);
        chk_eq("R2 disp_a", disp_a, 11);
        chk_eq("R2 disp_b", disp_b, 22);
        chk_eq("R2 disp_tag", disp_tag, 4);
        chk_eq("R2 next slot tag", iss_tag, 5);
        tick();
        chk_eq("R8 executing not redispatched", disp_valid, 0);
        fu_done = 1'b1; fu_done_tag = 4'd4;
        tick();
        chk_eq("R8 completed still holds slot", iss_tag, 5);
        bcast(4'd4, 0);
        chk_eq("R8 slot freed", iss_tag, 4);
    endtask

    task automatic t_wakeup();
        drive_issue(4'd5, 4'd8, 0, 4'd0, 2);
        tick();
        drive_issue(4'd6, 4'd8, 0, 4'd9, 0);
        tick();
        chk_eq("R9 pending operands hold", disp_valid, 0);
        bcast(4'd8, 100);
        chk_eq("R3 wake slot0 valid", disp_valid, 1);
        chk_eq("R3 wake slot0 tag", disp_tag, 4);
        chk_eq("R3 wake slot0 a", disp_a, 100);
        chk_eq("R3 wake slot0 b", disp_b, 2);
        tick();
        chk_eq("R9 one operand pending", disp_valid, 0);
        bcast(4'd9, 200);
        chk_eq("R3 slot1 tag", disp_tag, 5);
        chk_eq("R3 slot1 a from shared broadcast", disp_a, 100);
        chk_eq("R3 slot1 b", disp_b, 200);
        chk_eq("R3 slot1 op", disp_op, 6);
        tick();
        finish_slot(4'd4);
        finish_slot(4'd5);
        chk_eq("R8 both freed", iss_tag, 4);
    endtask

    task automatic t_bypass();
        drive_issue(4'd7, 4'd10, 0, 4'd0, 7);
        bus_valid = 1'b1; bus_tag = 4'd10; bus_data = DW'(55);
        tick();
        chk_eq("R4 bypass dispatch", disp_valid, 1);
        chk_eq("R4 bypass value", disp_a, 55);
        chk_eq("R4 bypass b", disp_b, 7);
        tick();
        finish_slot(4'd4);
    endtask

    task automatic t_stall();
        fu_busy = 1'b1;
        for (int k = 0; k < 4; k++) begin
            drive_issue(4'(k + 1), 4'd12, 0, 4'd0, k);
            tick();
        end
        chk_eq("R5 stall when full", iss_stall, 1);
        drive_issue(4'd9, 4'd0, 1, 4'd0, 1);
        tick();
        chk_eq("R5 stall persists", iss_stall, 1);
        bcast(4'd12, 3);
        chk_eq("R7 busy holds dispatch", disp_valid, 0);
        tick();
        chk_eq("R7 still held", disp_valid, 0);
        fu_busy = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk_eq("R6 dispatch order", disp_tag, 4 + k);
            chk_eq("R5 refused issue absent", disp_op, k + 1);
            chk_eq("R3 all woken by one broadcast", disp_a, 3);
            tick();
        end
        chk_eq("R5 no stray dispatch", disp_valid, 0);
        for (int k = 0; k < 4; k++) finish_slot(4'(4 + k));
        chk_eq("R5 stall cleared", iss_stall, 0);
    endtask

    task automatic t_oldest();
        drive_issue(4'd1, 4'd8, 0, 4'd0, 1);
        tick();
        drive_issue(4'd2, 4'd9, 0, 4'd0, 2);
        tick();
        bcast(4'd8, 1);
        tick();
        finish_slot(4'd4);
        drive_issue(4'd12, 4'd9, 0, 4'd0, 3);
        #1 chk_eq("R2 reuses slot0", iss_tag, 4);
        tick();
        fu_busy = 1'b1;
        bcast(4'd9, 77);
        chk_eq("R7 hold two ready", disp_valid, 0);
        fu_busy = 1'b0;
        #1;
        chk_eq("R6 older higher index first", disp_tag, 5);
        tick();
        chk_eq("R6 younger next", disp_tag, 4);
        chk_eq("R6 younger op", disp_op, 12);
        tick();
        finish_slot(4'd5);
        finish_slot(4'd4);
        chk_eq("R8 all free again", iss_stall, 0);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_ready_issue();
        t_wakeup();
        t_bypass();
        t_stall();
        t_oldest();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule